// File: doc/BRIEF.md
# Power-on strap latch sequencer

This block takes a snapshot of six configuration straps once after power-up and then hands their shared pins over to clock outputs. Five frequency-select straps and one multiplier strap are read while the power-good pin is low. The first rising edge of power-good after reset freezes their values into a holding register. After that the strap pins are released to drive their clocks, and the power-good pin takes on a second role as an active-low power-down request for the rest of operation.

All pin inputs pass through a synchronizer of `SYNC_STAGES` flops (two by default) before use. The straps and power-good share the same synchronizer depth, so the captured word comes from the same clock edge that first sees power-good high. The output enables rise one cycle after the capture, so no pin drives while its value is still being taken. Only a reset can re-arm the capture. The synchronizers reset low, so a power-good pin that is already high when reset is released counts as the first rising edge.

Top module: `strap_latch_seq`

## Requirements
- R1: While `rst_ni` is low, `latched_o`, `strap_word_o`, `pin_oe_o` and `pwrdn_req_o` are all zero.
- R2: If `pwrgd_i` is first sampled high at clock edge k and was low at edge k-1, with no capture since reset, `latched_o` goes high after edge k+2.
- R3: The captured word holds the strap inputs sampled at edge k. Bits 4:0 are frequency-select straps 0 to 4 (bit i is strap i), and bit 5 is the multiplier strap.
- R4: Once captured, `strap_word_o` does not change when the straps change or when `pwrgd_i` rises again.
- R5: `pin_oe_o` (6 bits, same bit order as the word) is all zero until the cycle after `latched_o` first goes high, and all ones from then on.
- R6: Before capture, `pwrdn_req_o` stays low whatever the level of `pwrgd_i`.
- R7: After capture, if `pwrgd_i` is sampled low at edge m, `pwrdn_req_o` is high after edge m+2 and falls again with the same two-cycle delay once the pin returns high.
- R8: After capture, `latched_o` stays high until reset. A reset followed by a new power-good rising edge captures fresh strap values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| strap_fs_i | input | 5 | Frequency-select strap inputs (bit i = strap i) |
| strap_mult_i | input | 1 | Multiplier strap input |
| pwrgd_i | input | 1 | Power-good before capture, active-low power-down after |
| strap_word_o | output | 6 | Captured strap word {mult, fs[4:0]} |
| latched_o | output | 1 | High once the straps have been captured |
| pin_oe_o | output | 6 | Output enables for the shared strap pins |
| pwrdn_req_o | output | 1 | Power-down request |

## Verification
The assertions check on every cycle that the capture flag is sticky and the word stays frozen after capture. They also check that the output enables are zero before capture, lag the capture by exactly one cycle, and then stay set, and that no power-down request appears before capture. Only the bench scenarios can show that the right strap values are taken at the right edge through the synchronizer delay, that later power-good edges are ignored, and that the power-down request tracks the pin with its two-cycle latency. The same holds for reset re-arming the capture, including release with power-good already high.

// File: rtl/strap_seq_pkg.sv
package strap_seq_pkg;
  localparam int unsigned NUM_FS     = 5;
  localparam int unsigned NUM_MULT   = 1;
  localparam int unsigned STRAP_W    = NUM_FS + NUM_MULT;

  typedef enum logic [1:0] {
    SEQ_SAMPLE = 2'd0,
    SEQ_ARM    = 2'd1,
    SEQ_RUN    = 2'd2
  } seq_state_e;
endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] stage_d;
    if (s == 0) begin : g_first
      assign stage_d = d_i;
    end else begin : g_next
      assign stage_d = stage_q[s-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else         stage_q[s] <= stage_d;
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/strap_seq_ctrl.sv
module strap_seq_ctrl
  import strap_seq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pg_sync_i,
  output logic capture_o,
  output logic latched_o,
  output logic oe_en_o,
  output logic pwrdn_req_o
);
  seq_state_e state_q, state_d;
  logic       pg_prev_q;
  logic       pwrdn_q, pwrdn_d;
  logic       pg_rise;

  assign pg_rise = pg_sync_i & ~pg_prev_q;

  always_comb begin
    state_d   = state_q;
    capture_o = 1'b0;
    unique case (state_q)
      SEQ_SAMPLE: begin
        if (pg_rise) begin
          capture_o = 1'b1;
          state_d   = SEQ_ARM;
        end
      end
      SEQ_ARM: state_d = SEQ_RUN;
      SEQ_RUN: state_d = SEQ_RUN;
      default: state_d = SEQ_SAMPLE;
    endcase
  end

  assign latched_o = (state_q != SEQ_SAMPLE);
  assign oe_en_o   = (state_q == SEQ_RUN);
  assign pwrdn_d   = latched_o & ~pg_sync_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= SEQ_SAMPLE;
      pg_prev_q <= 1'b0;
      pwrdn_q   <= 1'b0;
    end else begin
      state_q   <= state_d;
      pg_prev_q <= pg_sync_i;
      pwrdn_q   <= pwrdn_d;
    end
  end

  assign pwrdn_req_o = pwrdn_q;
endmodule

// File: rtl/strap_hold_reg.sv
module strap_hold_reg #(
  parameter int unsigned WIDTH = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] hold_q, hold_d;

  always_comb begin
    hold_d = hold_q;
    if (load_i) hold_d = d_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hold_q <= '0;
    else         hold_q <= hold_d;
  end

  assign q_o = hold_q;
endmodule

// File: rtl/strap_latch_seq.sv
module strap_latch_seq
  import strap_seq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_FS-1:0]  strap_fs_i,
  input  logic               strap_mult_i,
  input  logic               pwrgd_i,
  output logic [STRAP_W-1:0] strap_word_o,
  output logic               latched_o,
  output logic [STRAP_W-1:0] pin_oe_o,
  output logic               pwrdn_req_o
);
  localparam int unsigned SYNC_W = STRAP_W + 1;

  logic [SYNC_W-1:0]  raw_bus, sync_bus;
  logic [STRAP_W-1:0] strap_sync_w;
  logic               pg_sync;
  logic               capture;
  logic               oe_en;

  assign raw_bus      = {pwrgd_i, strap_mult_i, strap_fs_i};
  assign strap_sync_w = sync_bus[STRAP_W-1:0];
  assign pg_sync      = sync_bus[SYNC_W-1];

  strap_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (raw_bus),
    .q_o    (sync_bus)
  );

  strap_seq_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pg_sync_i   (pg_sync),
    .capture_o   (capture),
    .latched_o   (latched_o),
    .oe_en_o     (oe_en),
    .pwrdn_req_o (pwrdn_req_o)
  );

  strap_hold_reg #(.WIDTH(STRAP_W)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (capture),
    .d_i    (strap_sync_w),
    .q_o    (strap_word_o)
  );

  assign pin_oe_o = {STRAP_W{oe_en}};
endmodule

// File: rtl/strap_latch_seq_chk.sv
module strap_latch_seq_chk
  import strap_seq_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic [STRAP_W-1:0] strap_word_o,
  input logic               latched_o,
  input logic [STRAP_W-1:0] pin_oe_o,
  input logic               pwrdn_req_o
);
  // R8: capture flag is sticky until reset
  a_r8_latched_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latched_o |=> latched_o);

  // R4: frozen word after capture
  a_r4_word_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latched_o && $past(latched_o)) |-> $stable(strap_word_o));

  // R5: enables stay off in the capture cycle, then turn fully on
  a_r5_oe_lag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(latched_o) |-> (pin_oe_o == '0));

  a_r5_oe_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(latched_o) |=> (pin_oe_o == '1));

  a_r5_oe_off_unlatched: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !latched_o |-> (pin_oe_o == '0));

  // R6: no power-down request before capture
  a_r6_no_pwrdn_early: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwrdn_req_o |-> latched_o);
endmodule

bind strap_latch_seq strap_latch_seq_chk i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .strap_word_o (strap_word_o),
  .latched_o    (latched_o),
  .pin_oe_o     (pin_oe_o),
  .pwrdn_req_o  (pwrdn_req_o)
);

// File: tb/test_strap_latch_seq.sv
module test_strap_latch_seq;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic [4:0] strap_fs_i;
  logic       strap_mult_i;
  logic       pwrgd_i;
  logic [5:0] strap_word_o;
  logic       latched_o;
  logic [5:0] pin_oe_o;
  logic       pwrdn_req_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  strap_latch_seq i_strap_latch_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .strap_fs_i   (strap_fs_i),
    .strap_mult_i (strap_mult_i),
    .pwrgd_i      (pwrgd_i),
    .strap_word_o (strap_word_o),
    .latched_o    (latched_o),
    .pin_oe_o     (pin_oe_o),
    .pwrdn_req_o  (pwrdn_req_o)
  );

  // Behavioural reference: input histories by clock edge
  bit       pg_hist[$];
  bit [5:0] st_hist[$];
  bit       m_latched, m_pd;
  bit       m_oe;
  bit [5:0] m_word;

  task automatic model_clear();
    pg_hist = '{0, 0, 0};
    st_hist = '{0, 0, 0};
    m_latched = 0; m_pd = 0; m_oe = 0; m_word = '0;
  endtask

  initial model_clear();

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      model_clear();
    end else begin
      // pg_hist[1] = sampled two edges ago, pg_hist[2] = three edges ago
      bit rise;
      rise  = pg_hist[1] && !pg_hist[2];
      m_oe  = m_latched;
      m_pd  = m_latched && !pg_hist[1];
      if (!m_latched && rise) begin
        m_latched = 1;
        m_word    = st_hist[1];
      end
      pg_hist.push_front(pwrgd_i);
      st_hist.push_front({strap_mult_i, strap_fs_i});
      void'(pg_hist.pop_back());
      void'(st_hist.pop_back());
    end
  end

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk_i) begin
    if (!done) begin
      check("R2 latched", latched_o, m_latched);
      check("R3 word", strap_word_o, m_word);
      check("R5 oe", pin_oe_o, m_oe ? 6'h3f : 6'h00);
      check("R7 pwrdn", pwrdn_req_o, m_pd);
    end
  end

  task automatic step(int n);
    repeat (n) begin
      @(posedge clk_i);
      #(CLK_PERIOD/4);
    end
  endtask

  initial begin
    rst_ni = 1'b0;
    strap_fs_i = 5'b00000;
    strap_mult_i = 1'b1;
    pwrgd_i = 1'b0;
    step(3);
    // R1 reset state
    check("R1 latched", latched_o, 0);
    check("R1 word", strap_word_o, 0);
    check("R1 oe", pin_oe_o, 0);
    check("R1 pwrdn", pwrdn_req_o, 0);
    rst_ni = 1'b1;
    strap_fs_i = 5'b10110;
    strap_mult_i = 1'b0;
    step(6);
    // R6 pin low before capture is not a power-down
    check("R6 pwrdn early", pwrdn_req_o, 0);
    check("R6 oe early", pin_oe_o, 0);
    pwrgd_i = 1'b1;
    step(1);  // sampled high at this edge k
    step(1);
    check("R2 not yet", latched_o, 0);
    step(1);
    check("R2 latched k+2", latched_o, 1);
    check("R5 oe lags", pin_oe_o, 6'h00);
    check("R3 word value", strap_word_o, 6'b010110);
    strap_fs_i = 5'b01001;
    strap_mult_i = 1'b1;
    step(1);
    check("R5 oe on", pin_oe_o, 6'h3f);
    step(3);
    // R7 power-down request
    pwrgd_i = 1'b0;
    step(2);
    check("R7 pd not yet", pwrdn_req_o, 0);
    step(1);
    check("R7 pd m+2", pwrdn_req_o, 1);
    pwrgd_i = 1'b1;
    step(3);
    check("R7 pd released", pwrdn_req_o, 0);
    step(3);
    check("R4 no relatch", strap_word_o, 6'b010110);
    check("R8 still latched", latched_o, 1);
    // R8 reset re-arms, release with power-good already high
    rst_ni = 1'b0;
    step(1);
    check("R1 word cleared", strap_word_o, 0);
    check("R8 cleared", latched_o, 0);
    rst_ni = 1'b1;
    step(6);
    check("R8 fresh capture", strap_word_o, 6'b101001);
    check("R8 relatched", latched_o, 1);
    // one-cycle low pulse on power-down pin
    pwrgd_i = 1'b0;
    step(1);
    pwrgd_i = 1'b1;
    step(5);
    check("R4 word after pulse", strap_word_o, 6'b101001);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule